// File: doc/BRIEF.md
# Multi-channel event timer register front end

This block is the register front end of an event timer that has one shared 32-bit main counter and eight comparator channels. A bus master issues single-cycle requests of 4 or 8 bytes. The block decodes the global registers itself: a read-only capability word, a configuration word with the global enable, an interrupt-status word and the main counter. Accesses to a channel's configuration, comparator or message register are passed to the channel logic as a one-hot write strobe with lane-placed data and byte-lane mask. Reads of channel registers are taken from a flattened read bus that the channel logic supplies.

The main counter lives here. It advances on each cycle where the tick enable is high and the global enable is set. Clearing the global enable freezes the counter. Setting it again resumes counting from the frozen value and pulses a restart strobe, so that the channels re-arm their compares. The interrupt-status bits are set by channel events and cleared by writing ones.

Top module: `timer_regif`

## Requirements
- R1: Only request sizes of 4 and 8 bytes are accepted. A write of any other size changes nothing, and a read of any other size returns zero.
- R2: A request whose byte offset is not a multiple of its size changes nothing on write and returns zero on read.
- R3: A 4-byte access with offset bit 2 set targets bits 63:32 of the 64-bit register: write data and mask move up by 32, and the read returns the upper half in bits 31:0. A 4-byte access with bit 2 clear returns the lower half, zero-extended.
- R4: The capability register at offset 0x000 cannot be written. It reads as revision 1 in bits 7:0, the channel count minus one in bits 12:8, zero in bits 15:13 (the zero in bit 13 marks a 32-bit counter), the vendor code 0x8086 in bits 31:16 and the tick period in femtoseconds (100000000) in bits 63:32.
- R5: The configuration register at 0x010 stores what is written, except bit 1 (legacy routing), which always reads zero. Bit 0 is the global enable and is driven on `cnt_en_o`.
- R6: While the global enable is set, the main counter adds one on each cycle with `tick_i` high and wraps modulo 2^32.
- R7: While the global enable is clear, the counter holds its value. A write that sets the enable makes `restart_o` high for one cycle, and counting resumes from the held value.
- R8: The interrupt-status register at 0x020 sets bit n when `ch_irq_set_i[n]` is high. A write clears only the bits that are written as one. A set that coincides with a clear of the same bit wins.
- R9: The main counter at 0x0F0 can be written and reads zero-extended to 64 bits. A write takes priority over a tick in the same cycle. A counter write while the enable is set pulses `restart_o`.
- R10: A valid write to channel n (base 0x100 + 0x20*n; configuration at +0x00, comparator at +0x08, message at +0x10) raises only `ch_wr_o[n]` in the same cycle. It also drives `ch_reg_o` to 0, 1 or 2 for those three registers, and drives the lane-placed data and mask on `ch_wdata_o` and `ch_wmask_o`.
- R11: A read of channel n register r returns slice (3*n + r) of `ch_rdata_i`, 64 bits each. A read of any offset with no register returns zero.
- R12: Read data and `rd_valid_o` appear one cycle after the read request. `rd_valid_o` stays low after writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter tick enable |
| req_valid_i | input | 1 | Request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset |
| req_size_i | input | 4 | Request size in bytes |
| req_wdata_i | input | 64 | Write data, lane 0 aligned |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 64 | Registered read data |
| counter_o | output | CNT_W | Main counter value |
| cnt_en_o | output | 1 | Global enable |
| restart_o | output | 1 | Channel compare restart strobe |
| ch_irq_set_i | input | NCH | Per-channel status set events |
| isr_o | output | NCH | Interrupt status, level lines |
| ch_wr_o | output | NCH | One-hot channel write strobe |
| ch_reg_o | output | 2 | Channel register select |
| ch_wdata_o | output | 64 | Lane-placed write data |
| ch_wmask_o | output | 64 | Write lane mask |
| ch_rdata_i | input | NCH*3*64 | Channel register read values |

## Verification
Two pairs of functions can fall in the same cycle. The first is a counter write and a tick. The bench holds `tick_i` high in the very cycle of a counter write and expects the written value with no increment. The second is a write-one-to-clear of the status register and a channel set event. The bench drives `ch_irq_set_i` during the clearing write, both directed and from random patterns. It judges the result against a bench model in which a set beats a clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {G_NONE, G_CAP, G_CFG, G_ISR, G_CNT, G_CH} sel_e;
  typedef enum logic [1:0] {CH_CFG = 2'd0, CH_CMP = 2'd1, CH_MSG = 2'd2, CH_NONE = 2'd3} ch_reg_e;

  localparam int OFF_CAP     = 'h000;
  localparam int OFF_CFG     = 'h010;
  localparam int OFF_ISR     = 'h020;
  localparam int OFF_CNT     = 'h0F0;
  localparam int OFF_CH      = 'h100;
  localparam int CH_STRIDE   = 'h20;
  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_LEG_BIT = 1;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 12,
  parameter int CH_W   = 3
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        size_i,
  input  logic [63:0]       wdata_i,
  output logic              ok_o,
  output logic              hi_o,
  output logic              half_o,
  output sel_e              sel_o,
  output logic [CH_W-1:0]   ch_idx_o,
  output ch_reg_e           ch_reg_o,
  output logic [63:0]       mask_o,
  output logic [63:0]       data_o
);
  localparam logic [ADDR_W-1:0] CH_LO = ADDR_W'(OFF_CH);
  localparam logic [ADDR_W-1:0] CH_HI = ADDR_W'(OFF_CH + NCH * CH_STRIDE);

  logic              size_ok, align_ok;
  logic [ADDR_W-1:0] qaddr, rel;

  always_comb begin
    size_ok  = (size_i == 4'd4) || (size_i == 4'd8);
    align_ok = (size_i == 4'd8) ? (addr_i[2:0] == 3'b000) : (addr_i[1:0] == 2'b00);
    ok_o     = valid_i && size_ok && align_ok;
    half_o   = (size_i == 4'd4);
    hi_o     = half_o && addr_i[2];
    if (!half_o)   begin mask_o = '1;                     data_o = wdata_i;                 end
    else if (hi_o) begin mask_o = {32'hFFFF_FFFF, 32'h0}; data_o = {wdata_i[31:0], 32'h0};  end
    else           begin mask_o = {32'h0, 32'hFFFF_FFFF}; data_o = {32'h0, wdata_i[31:0]};  end

    qaddr    = {addr_i[ADDR_W-1:3], 3'b000};
    rel      = qaddr - CH_LO;
    ch_idx_o = rel[5 +: CH_W];
    ch_reg_o = ch_reg_e'(rel[4:3]);
    sel_o    = G_NONE;
    if      (qaddr == ADDR_W'(OFF_CAP)) sel_o = G_CAP;
    else if (qaddr == ADDR_W'(OFF_CFG)) sel_o = G_CFG;
    else if (qaddr == ADDR_W'(OFF_ISR)) sel_o = G_ISR;
    else if (qaddr == ADDR_W'(OFF_CNT)) sel_o = G_CNT;
    else if (qaddr >= CH_LO && qaddr < CH_HI && ch_reg_o != CH_NONE) sel_o = G_CH;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (ld_i)            cnt_o <= ld_val_i;
    else if (en_i && tick_i)  cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/tmr_status.sv
module tmr_status #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic           clr_en_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] isr_o
);
  logic [NCH-1:0] clr_eff;
  assign clr_eff = clr_en_i ? clr_i : '0;

  // set beats clear so a fresh event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= (isr_o & ~clr_eff) | set_i;
  end
endmodule

// File: rtl/timer_regif.sv
module timer_regif
  import tmr_pkg::*;
#(
  parameter int          NCH       = 8,
  parameter int          ADDR_W    = 12,
  parameter int          CNT_W     = 32,
  parameter logic [15:0] VENDOR_ID = 16'h8086,
  parameter logic [31:0] PERIOD_FS = 32'd100_000_000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [3:0]          req_size_i,
  input  logic [63:0]         req_wdata_i,
  output logic                rd_valid_o,
  output logic [63:0]         rd_data_o,
  output logic [CNT_W-1:0]    counter_o,
  output logic                cnt_en_o,
  output logic                restart_o,
  input  logic [NCH-1:0]      ch_irq_set_i,
  output logic [NCH-1:0]      isr_o,
  output logic [NCH-1:0]      ch_wr_o,
  output logic [1:0]          ch_reg_o,
  output logic [63:0]         ch_wdata_o,
  output logic [63:0]         ch_wmask_o,
  input  logic [NCH*3*64-1:0] ch_rdata_i
);
  localparam int          CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [63:0] CAP  = {PERIOD_FS, VENDOR_ID, 3'b000, 5'(NCH - 1), 8'h01};

  logic            ok, hi, half;
  sel_e            sel;
  logic [CH_W-1:0] ch_idx;
  ch_reg_e         ch_reg;
  logic [63:0]     mask, data;

  tmr_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W)) u_dec (
    .valid_i (req_valid_i), .addr_i (req_addr_i), .size_i (req_size_i),
    .wdata_i (req_wdata_i), .ok_o (ok), .hi_o (hi), .half_o (half),
    .sel_o (sel), .ch_idx_o (ch_idx), .ch_reg_o (ch_reg),
    .mask_o (mask), .data_o (data)
  );

  logic wr_ok, rd_req;
  assign wr_ok  = ok && req_write_i;
  assign rd_req = req_valid_i && !req_write_i;

  // configuration
  logic [63:0] cfg_q, cfg_d;
  logic        cfg_wr, cnt_wr, en_next;
  assign cfg_wr = wr_ok && (sel == G_CFG);
  assign cnt_wr = wr_ok && (sel == G_CNT);

  always_comb begin
    cfg_d = (cfg_q & ~mask) | (data & mask);
    cfg_d[CFG_LEG_BIT] = 1'b0;
    en_next = cfg_wr ? cfg_d[CFG_EN_BIT] : cfg_q[CFG_EN_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      restart_o <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_d;
      restart_o <= (en_next && !cfg_q[CFG_EN_BIT]) || (cnt_wr && cfg_q[CFG_EN_BIT]);
    end
  end
  assign cnt_en_o = cfg_q[CFG_EN_BIT];

  // main counter
  logic [CNT_W-1:0] ld_val;
  assign ld_val = (counter_o & ~mask[CNT_W-1:0]) | (data[CNT_W-1:0] & mask[CNT_W-1:0]);

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (cnt_en_o), .tick_i (tick_i),
    .ld_i (cnt_wr), .ld_val_i (ld_val), .cnt_o (counter_o)
  );

  // interrupt status
  tmr_status #(.NCH(NCH)) u_isr (
    .clk_i (clk_i), .rst_ni (rst_ni), .set_i (ch_irq_set_i),
    .clr_en_i (wr_ok && (sel == G_ISR)), .clr_i (data[NCH-1:0] & mask[NCH-1:0]),
    .isr_o (isr_o)
  );

  // channel write forwarding
  for (genvar g = 0; g < NCH; g++) begin : g_chwr
    assign ch_wr_o[g] = wr_ok && (sel == G_CH) && (ch_idx == CH_W'(g));
  end
  assign ch_reg_o   = ch_reg;
  assign ch_wdata_o = data;
  assign ch_wmask_o = mask;

  // read mux
  logic [63:0] rmux, rlane;
  always_comb begin
    unique case (sel)
      G_CAP:   rmux = CAP;
      G_CFG:   rmux = cfg_q;
      G_ISR:   rmux = 64'(isr_o);
      G_CNT:   rmux = 64'(counter_o);
      G_CH:    rmux = ch_rdata_i[(int'(ch_idx) * 3 + int'(ch_reg)) * 64 +: 64];
      default: rmux = '0;
    endcase
    if (!half)   rlane = rmux;
    else if (hi) rlane = {32'h0, rmux[63:32]};
    else         rlane = {32'h0, rmux[31:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_req;
      if (rd_req) rd_data_o <= ok ? rlane : 64'h0;
    end
  end
endmodule

// File: rtl/timer_regif_chk.sv
module timer_regif_chk #(
  parameter int          NCH       = 8,
  parameter int          ADDR_W    = 12,
  parameter int          CNT_W     = 32,
  parameter logic [15:0] VENDOR_ID = 16'h8086,
  parameter logic [31:0] PERIOD_FS = 32'd100_000_000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [3:0]        req_size_i,
  input logic              rd_valid_o,
  input logic [63:0]       rd_data_o,
  input logic [CNT_W-1:0]  counter_o,
  input logic              cnt_en_o,
  input logic [NCH-1:0]    ch_irq_set_i,
  input logic [NCH-1:0]    isr_o,
  input logic [NCH-1:0]    ch_wr_o
);
  localparam logic [63:0] CAP_EXP = {PERIOD_FS, VENDOR_ID, 3'b000, 5'(NCH - 1), 8'h01};

  logic rd;
  assign rd = req_valid_i && !req_write_i;

  p_bad_size_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && req_size_i != 4'd4 && req_size_i != 4'd8 |=> rd_data_o == 64'h0);

  p_cap_value_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && req_size_i == 4'd8 && req_addr_i == ADDR_W'('h000) |=> rd_data_o == CAP_EXP);

  p_legacy_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && req_size_i == 4'd8 && req_addr_i == ADDR_W'('h010) |=> !rd_data_o[1]);

  p_tick_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_o && tick_i && !req_valid_i |=> counter_o == $past(counter_o) + CNT_W'(1));

  p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en_o && !req_valid_i |=> $stable(counter_o));

  p_set_lands_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_irq_set_i != '0 |=> (isr_o & $past(ch_irq_set_i)) == $past(ch_irq_set_i));

  p_wr_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wr_o));

  p_wr_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_wr_o != '0 |-> req_valid_i && req_write_i);

  p_rd_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rd_valid_o);
endmodule

bind timer_regif timer_regif_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .VENDOR_ID(VENDOR_ID), .PERIOD_FS(PERIOD_FS)
) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i), .req_valid_i (req_valid_i),
  .req_write_i (req_write_i), .req_addr_i (req_addr_i), .req_size_i (req_size_i),
  .rd_valid_o (rd_valid_o), .rd_data_o (rd_data_o), .counter_o (counter_o),
  .cnt_en_o (cnt_en_o), .ch_irq_set_i (ch_irq_set_i), .isr_o (isr_o), .ch_wr_o (ch_wr_o)
);

// File: tb/sim_timer_regif.sv
module sim_timer_regif;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NCH = 8;
  localparam int AW  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              valid = 1'b0;
  logic              write = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [3:0]        size = 4'd8;
  logic [63:0]       wdata = '0;
  logic              rd_valid;
  logic [63:0]       rd_data;
  logic [31:0]       counter;
  logic              cnt_en, restart;
  logic [NCH-1:0]    irq_set = '0;
  logic [NCH-1:0]    isr;
  logic [NCH-1:0]    ch_wr;
  logic [1:0]        ch_reg;
  logic [63:0]       ch_wdata, ch_wmask;
  logic [NCH*3*64-1:0] ch_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [NCH-1:0] c_wr;
  logic [1:0]     c_reg;
  logic [63:0]    c_wd, c_wm;

  always #2.5 clk = ~clk;

  timer_regif u0 (
    .clk_i (clk), .rst_ni (rst_n), .tick_i (tick), .req_valid_i (valid),
    .req_write_i (write), .req_addr_i (addr), .req_size_i (size), .req_wdata_i (wdata),
    .rd_valid_o (rd_valid), .rd_data_o (rd_data), .counter_o (counter),
    .cnt_en_o (cnt_en), .restart_o (restart), .ch_irq_set_i (irq_set), .isr_o (isr),
    .ch_wr_o (ch_wr), .ch_reg_o (ch_reg), .ch_wdata_o (ch_wdata), .ch_wmask_o (ch_wmask),
    .ch_rdata_i (ch_rdata)
  );

  function automatic logic [63:0] pat(int i, int r);
    return {8'(i), 8'(r), 16'hA5C3, 32'h1000_0000 + 32'(i * 16 + r)};
  endfunction

  function automatic logic [63:0] cap_exp();
    return {32'd100_000_000, 16'h8086, 3'b000, 5'(NCH - 1), 8'h01};
  endfunction

  function automatic logic [AW-1:0] ch_addr(int ch, int r, bit up);
    return AW'('h100 + ch * 'h20 + r * 8 + (up ? 4 : 0));
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one request cycle; comb outputs captured before the edge, registered after
  task automatic bus(bit wr, logic [AW-1:0] a, logic [63:0] d, logic [3:0] sz,
                     logic [NCH-1:0] irq, bit tk);
    @(negedge clk);
    valid = 1'b1; write = wr; addr = a; wdata = d; size = sz; irq_set = irq; tick = tk;
    #1;
    c_wr = ch_wr; c_reg = ch_reg; c_wd = ch_wdata; c_wm = ch_wmask;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; irq_set = '0; tick = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [3:0] sz, logic [63:0] exp);
    bus(1'b0, a, 64'h0, sz, '0, 1'b0);
    chk(req, rd_data, exp);
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] m_isr;
    void'($urandom(32'd4242));
    for (int i = 0; i < NCH; i++)
      for (int r = 0; r < 3; r++) ch_rdata[(i * 3 + r) * 64 +: 64] = pat(i, r);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset counter", 64'(counter), 64'h0);
    chk("reset isr", 64'(isr), 64'h0);
    chk("reset enable", 64'(cnt_en), 64'h0);
    chk("reset rd_valid", 64'(rd_valid), 64'h0);

    // R4 capability
    rd_chk("R4 cap 8B", AW'('h000), 4'd8, cap_exp());
    rd_chk("R4 cap low 4B", AW'('h000), 4'd4, {32'h0, cap_exp() >> 32 << 32 ^ cap_exp()} & 64'hFFFF_FFFF);
    rd_chk("R3 cap high 4B", AW'('h004), 4'd4, {32'h0, cap_exp()[63:32]});
    bus(1'b1, AW'('h000), '1, 4'd8, '0, 1'b0);
    rd_chk("R4 cap read-only", AW'('h000), 4'd8, cap_exp());
    chk("R12 rd_valid after read", 64'(rd_valid), 64'h1);
    bus(1'b1, AW'('h010), 64'h0, 4'd8, '0, 1'b0);
    chk("R12 rd_valid low after write", 64'(rd_valid), 64'h0);

    // R5 config, legacy bit forced zero
    bus(1'b1, AW'('h010), 64'hFFFF_0000_0000_00FE, 4'd8, '0, 1'b0);
    rd_chk("R5 legacy reads zero", AW'('h010), 4'd8, 64'hFFFF_0000_0000_00FC);
    chk("R5 enable clear", 64'(cnt_en), 64'h0);
    bus(1'b1, AW'('h014), 64'h0, 4'd4, '0, 1'b0);
    rd_chk("R3 upper config write", AW'('h010), 4'd8, 64'h0000_0000_0000_00FC);
    bus(1'b1, AW'('h010), 64'h0, 4'd8, '0, 1'b0);

    // R6 count and wrap
    bus(1'b1, AW'('h0F0), 64'hFFFF_FFFE, 4'd8, '0, 1'b0);
    chk("R9 load while disabled no restart", 64'(restart), 64'h0);
    bus(1'b1, AW'('h010), 64'h1, 4'd8, '0, 1'b0);
    chk("R7 restart on enable", 64'(restart), 64'h1);
    chk("R5 enable set", 64'(cnt_en), 64'h1);
    ticks(3);
    chk("R6 wrap", 64'(counter), 64'h1);
    rd_chk("R9 counter read 8B", AW'('h0F0), 4'd8, 64'h1);

    // R7 freeze and resume
    bus(1'b1, AW'('h010), 64'h0, 4'd8, '0, 1'b0);
    ticks(5);
    chk("R7 frozen", 64'(counter), 64'h1);
    bus(1'b1, AW'('h010), 64'h1, 4'd8, '0, 1'b0);
    chk("R7 restart pulse", 64'(restart), 64'h1);
    @(negedge clk);
    chk("R7 restart one cycle", 64'(restart), 64'h0);
    ticks(2);
    chk("R7 resume from held", 64'(counter), 64'h3);

    // R9 write beats tick in the same cycle
    bus(1'b1, AW'('h0F0), 64'h1234, 4'd4, '0, 1'b1);
    chk("R9 write beats tick", 64'(counter), 64'h1234);
    chk("R9 restart on counter write", 64'(restart), 64'h1);
    bus(1'b1, AW'('h0F4), 64'hFFFF, 4'd4, '0, 1'b0);
    chk("R9 upper write keeps count", 64'(counter), 64'h1234);
    rd_chk("R9 upper half zero", AW'('h0F4), 4'd4, 64'h0);
    rd_chk("R9 low 4B read", AW'('h0F0), 4'd4, 64'h1234);
    bus(1'b1, AW'('h010), 64'h0, 4'd8, '0, 1'b0);

    // R8 status
    bus(1'b0, AW'('h800), 64'h0, 4'd8, 8'h5A, 1'b0);
    chk("R8 set", 64'(isr), 64'h5A);
    bus(1'b1, AW'('h020), 64'h0F, 4'd8, '0, 1'b0);
    chk("R8 w1c", 64'(isr), 64'h50);
    rd_chk("R8 read", AW'('h020), 4'd8, 64'h50);
    bus(1'b1, AW'('h020), 64'h51, 4'd8, 8'h01, 1'b0);
    chk("R8 set and clear other bits", 64'(isr), 64'h01);
    bus(1'b1, AW'('h020), 64'h03, 4'd8, 8'h02, 1'b0);
    chk("R8 set wins same bit", 64'(isr), 64'h02);
    bus(1'b1, AW'('h024), 64'hFF, 4'd4, '0, 1'b0);
    chk("R3 upper isr write no clear", 64'(isr), 64'h02);

    // R1 bad sizes
    bus(1'b1, AW'('h010), 64'h1, 4'd2, '0, 1'b0);
    bus(1'b1, AW'('h010), 64'h1, 4'd1, '0, 1'b0);
    bus(1'b1, AW'('h010), 64'h1, 4'd15, '0, 1'b0);
    chk("R1 bad size write ignored", 64'(cnt_en), 64'h0);
    rd_chk("R1 bad size cfg", AW'('h010), 4'd8, 64'h0);
    rd_chk("R1 size 2 read", AW'('h000), 4'd2, 64'h0);
    rd_chk("R1 size 1 read", AW'('h000), 4'd1, 64'h0);

    // R2 misalignment
    rd_chk("R2 8B at 4", AW'('h004), 4'd8, 64'h0);
    rd_chk("R2 4B at 2", AW'('h002), 4'd4, 64'h0);
    bus(1'b1, AW'('h014), 64'h1, 4'd8, '0, 1'b0);
    bus(1'b1, AW'('h012), 64'h1, 4'd4, '0, 1'b0);
    chk("R2 misaligned write ignored", 64'(cnt_en), 64'h0);
    bus(1'b1, AW'('h10A), 64'h1, 4'd4, '0, 1'b0);
    chk("R2 misaligned channel write", 64'(c_wr), 64'h0);

    // R10 forwarding, R3 placement
    bus(1'b1, ch_addr(3, 1, 1'b1), 64'hDEAD_BEEF, 4'd4, '0, 1'b0);
    chk("R10 strobe", 64'(c_wr), 64'h08);
    chk("R10 reg sel", 64'(c_reg), 64'h1);
    chk("R3 upper data", c_wd, 64'hDEAD_BEEF_0000_0000);
    chk("R3 upper mask", c_wm, 64'hFFFF_FFFF_0000_0000);
    bus(1'b0, ch_addr(3, 1, 1'b0), 64'h0, 4'd8, '0, 1'b0);
    chk("R10 read gives no strobe", 64'(c_wr), 64'h0);

    // R11 reads
    rd_chk("R11 ch5 msg", ch_addr(5, 2, 1'b0), 4'd8, pat(5, 2));
    rd_chk("R11 ch7 cfg upper", ch_addr(7, 0, 1'b1), 4'd4, {32'h0, pat(7, 0)[63:32]});
    rd_chk("R11 unmapped 0x040", AW'('h040), 4'd8, 64'h0);
    rd_chk("R11 ch0 hole", AW'('h118), 4'd8, 64'h0);
    rd_chk("R11 past channels", AW'('h200), 4'd8, 64'h0);

    // random mix
    bus(1'b1, AW'('h020), 64'hFF, 4'd8, '0, 1'b0);
    m_isr = '0;
    for (int it = 0; it < 60; it++) begin
      logic [NCH-1:0] s, c;
      int ch, r;
      bit up;
      logic [31:0] d;
      s = NCH'($urandom); c = NCH'($urandom);
      bus(1'b1, AW'('h020), 64'(c), 4'd8, s, 1'b0);
      m_isr = (m_isr & ~c) | s;
      chk("R8 random", 64'(isr), 64'(m_isr));
      ch = int'($urandom % NCH); r = int'($urandom % 3); up = 1'($urandom); d = $urandom;
      bus(1'b1, ch_addr(ch, r, up), 64'(d), 4'd4, '0, 1'b0);
      chk("R10 random strobe", 64'(c_wr), 64'(NCH'(1) << ch));
      chk("R10 random data", c_wd, up ? {d, 32'h0} : {32'h0, d});
      rd_chk("R11 random read", ch_addr(ch, r, 1'b0), 4'd8, pat(ch, r));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule